// File: doc/BRIEF.md
# Display Memory Write Address Sequencer

This block supplies the write address for a banked display memory whose geometry is a row of byte-wide columns stacked in several banks (by default 102 columns and 9 banks, the last bank usable as an icon row). Each data byte written by the host is presented together with the address currently held. On the following clock edge the address advances, so a host can stream image bytes without issuing an address command per byte.

Two walking orders are offered. In horizontal order the column moves first and the bank steps when the column wraps. In vertical order the bank moves first and the column steps when the bank wraps. Both wrap points come from programmable column and bank limit registers. The walk can stop short of the array edge that way. A mirror option reflects the column seen by the memory, so logical column 0 lands on the last physical column. The host can also position the counters directly with separate column and bank load commands.

Top module: `disp_ram_addr_gen`

## Requirements
- R1: After reset the logical column and bank are 0. The order is horizontal, mirroring is off, the column limit is NUM_COLS-1 (101) and the bank limit is NUM_BANKS-1 (8). With no strobe, `mem_we` is 0 and `mem_col`/`mem_bank` read 0.
- R2: `mem_we` equals `wr_strobe` in the same cycle. A byte is written at the address shown in that cycle, and the advanced address appears only after the next rising clock edge.
- R3: In horizontal order (`cfg_vert`=0), a strobe with the column below its limit increments the column and leaves the bank unchanged.
- R4: In horizontal order, a strobe with the column at or above its limit returns the column to 0 and increments the bank.
- R5: In vertical order (`cfg_vert`=1), a strobe with the bank below its limit increments the bank and leaves the column unchanged.
- R6: In vertical order, a strobe with the bank at or above its limit returns the bank to 0 and increments the column.
- R7: In either order, a strobe with both the column and the bank at or above their limits returns both to 0.
- R8: With mirroring on (`cfg_mirror`=1), `mem_col` is NUM_COLS-1 minus the logical column. With mirroring off it equals the logical column. `mem_bank` is never mirrored.
- R9: A column load (`set_col`) or bank load (`set_bank`) replaces that counter on the next edge. The loaded value is clamped to the limit in force. A load has priority over the advance from a strobe in the same cycle. The axis that is not loaded keeps its value.
- R10: A configuration write (`cfg_wr`) takes effect on the next edge. It clamps the column limit to NUM_COLS-1 and the bank limit to NUM_BANKS-1. It does not change the counters, and a strobe in the same cycle still advances using the old settings.
- R11: With no strobe, no load and no configuration write, the address outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Data byte write strobe |
| set_col | input | 1 | Load the logical column counter |
| set_col_val | input | 7 | Column value to load |
| set_bank | input | 1 | Load the bank counter |
| set_bank_val | input | 4 | Bank value to load |
| cfg_wr | input | 1 | Write the order, mirror and limit settings |
| cfg_vert | input | 1 | 0: horizontal order, 1: vertical order |
| cfg_mirror | input | 1 | 1: mirror the column seen by the memory |
| cfg_col_lim | input | 7 | Column wrap limit |
| cfg_bank_lim | input | 4 | Bank wrap limit |
| mem_bank | output | 4 | Bank address to the memory |
| mem_col | output | 7 | Physical column address to the memory |
| mem_we | output | 1 | Write enable to the memory |

## Verification
The bench builds the block with its default geometry of 102 columns and 9 banks, with mirroring compiled in. Because of this, the clamps of limits and loads meet their real ceilings of 101 and 8, and loads of 127 and 15 exercise the clamp. A full horizontal sweep with the reset limits reaches the column 101 to column 0 wrap in about a hundred writes. The double wrap with both counters at their limits is reached with small programmed limits, in both orders, with and without mirroring.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic {
      ORDER_HORIZ = 1'b0,
      ORDER_VERT  = 1'b1
   } order_e;

endpackage

// File: rtl/dag_axis_step.sv
// One wrapping counter axis: next value and at-limit flag.
module dag_axis_step #(
   parameter int W = 7
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lim,
   input  logic         advance,
   output logic         at_lim,
   output logic [W-1:0] nxt
);

   always_comb begin
      at_lim = (cur >= lim);
      if (!advance)
         nxt = cur;
      else if (at_lim)
         nxt = '0;
      else
         nxt = cur + W'(1);
   end

endmodule

// File: rtl/dag_cfg_regs.sv
// Order, mirror and wrap-limit registers with clamping on write.
module dag_cfg_regs
   import dag_pkg::*;
#(
   parameter int COL_W    = 7,
   parameter int BANK_W   = 4,
   parameter int COL_MAX  = 101,
   parameter int BANK_MAX = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_vert,
   input  logic              cfg_mirror,
   input  logic [COL_W-1:0]  cfg_col_lim,
   input  logic [BANK_W-1:0] cfg_bank_lim,
   output order_e            order_q,
   output logic              mirror_q,
   output logic [COL_W-1:0]  col_lim_q,
   output logic [BANK_W-1:0] bank_lim_q
);

   localparam logic [COL_W-1:0]  COL_TOP  = COL_W'(COL_MAX);
   localparam logic [BANK_W-1:0] BANK_TOP = BANK_W'(BANK_MAX);

   logic [COL_W-1:0]  col_lim_clamped;
   logic [BANK_W-1:0] bank_lim_clamped;

   always_comb begin
      col_lim_clamped  = (cfg_col_lim  > COL_TOP)  ? COL_TOP  : cfg_col_lim;
      bank_lim_clamped = (cfg_bank_lim > BANK_TOP) ? BANK_TOP : cfg_bank_lim;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_q    <= ORDER_HORIZ;
         mirror_q   <= 1'b0;
         col_lim_q  <= COL_TOP;
         bank_lim_q <= BANK_TOP;
      end else if (cfg_wr) begin
         order_q    <= cfg_vert ? ORDER_VERT : ORDER_HORIZ;
         mirror_q   <= cfg_mirror;
         col_lim_q  <= col_lim_clamped;
         bank_lim_q <= bank_lim_clamped;
      end
   end

endmodule

// File: rtl/dag_counter.sv
// Logical column and bank counters with load and auto-advance.
module dag_counter
   import dag_pkg::*;
#(
   parameter int COL_W  = 7,
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic              set_col,
   input  logic [COL_W-1:0]  set_col_val,
   input  logic              set_bank,
   input  logic [BANK_W-1:0] set_bank_val,
   input  order_e            order_q,
   input  logic [COL_W-1:0]  col_lim_q,
   input  logic [BANK_W-1:0] bank_lim_q,
   output logic [COL_W-1:0]  col_q,
   output logic [BANK_W-1:0] bank_q
);

   logic              col_at_lim;
   logic              bank_at_lim;
   logic              col_adv;
   logic              bank_adv;
   logic              any_load;
   logic [COL_W-1:0]  col_step;
   logic [BANK_W-1:0] bank_step;
   logic [COL_W-1:0]  col_load;
   logic [BANK_W-1:0] bank_load;

   // The leading axis always moves; the trailing axis moves on wrap.
   always_comb begin
      if (order_q == ORDER_HORIZ) begin
         col_adv  = wr_strobe;
         bank_adv = wr_strobe & col_at_lim;
      end else begin
         bank_adv = wr_strobe;
         col_adv  = wr_strobe & bank_at_lim;
      end
   end

   dag_axis_step #(.W(COL_W)) u_col_step (
      .cur     (col_q),
      .lim     (col_lim_q),
      .advance (col_adv),
      .at_lim  (col_at_lim),
      .nxt     (col_step)
   );

   dag_axis_step #(.W(BANK_W)) u_bank_step (
      .cur     (bank_q),
      .lim     (bank_lim_q),
      .advance (bank_adv),
      .at_lim  (bank_at_lim),
      .nxt     (bank_step)
   );

   always_comb begin
      any_load  = set_col | set_bank;
      col_load  = (set_col_val  > col_lim_q)  ? col_lim_q  : set_col_val;
      bank_load = (set_bank_val > bank_lim_q) ? bank_lim_q : set_bank_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         bank_q <= '0;
      end else if (any_load) begin
         if (set_col)
            col_q <= col_load;
         if (set_bank)
            bank_q <= bank_load;
      end else begin
         col_q  <= col_step;
         bank_q <= bank_step;
      end
   end

endmodule

// File: rtl/dag_col_map.sv
// Logical to physical column mapping; mirror logic only when enabled.
module dag_col_map #(
   parameter int COL_W     = 7,
   parameter int NUM_COLS  = 102,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic [COL_W-1:0] col_log,
   input  logic             mirror,
   output logic [COL_W-1:0] col_phys
);

   localparam logic [COL_W-1:0] COL_TOP = COL_W'(NUM_COLS - 1);

   generate
      if (MIRROR_EN) begin : g_mirror
         assign col_phys = mirror ? (COL_TOP - col_log) : col_log;
      end else begin : g_plain
         logic unused_mirror;
         assign unused_mirror = mirror;
         assign col_phys      = col_log;
      end
   endgenerate

endmodule

// File: rtl/disp_ram_addr_gen.sv
module disp_ram_addr_gen
   import dag_pkg::*;
#(
   parameter int NUM_COLS  = 102,
   parameter int NUM_BANKS = 9,
   parameter bit MIRROR_EN = 1'b1,
   localparam int COL_W    = $clog2(NUM_COLS),
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic              set_col,
   input  logic [COL_W-1:0]  set_col_val,
   input  logic              set_bank,
   input  logic [BANK_W-1:0] set_bank_val,
   input  logic              cfg_wr,
   input  logic              cfg_vert,
   input  logic              cfg_mirror,
   input  logic [COL_W-1:0]  cfg_col_lim,
   input  logic [BANK_W-1:0] cfg_bank_lim,
   output logic [BANK_W-1:0] mem_bank,
   output logic [COL_W-1:0]  mem_col,
   output logic              mem_we
);

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("disp_ram_addr_gen: NUM_COLS must be at least 2");
      end
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("disp_ram_addr_gen: NUM_BANKS must be at least 2");
      end
   endgenerate

   order_e            order_q;
   logic              mirror_q;
   logic [COL_W-1:0]  col_lim_q;
   logic [BANK_W-1:0] bank_lim_q;
   logic [COL_W-1:0]  col_q;
   logic [BANK_W-1:0] bank_q;

   dag_cfg_regs #(
      .COL_W    (COL_W),
      .BANK_W   (BANK_W),
      .COL_MAX  (NUM_COLS - 1),
      .BANK_MAX (NUM_BANKS - 1)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_vert     (cfg_vert),
      .cfg_mirror   (cfg_mirror),
      .cfg_col_lim  (cfg_col_lim),
      .cfg_bank_lim (cfg_bank_lim),
      .order_q      (order_q),
      .mirror_q     (mirror_q),
      .col_lim_q    (col_lim_q),
      .bank_lim_q   (bank_lim_q)
   );

   dag_counter #(
      .COL_W  (COL_W),
      .BANK_W (BANK_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_strobe    (wr_strobe),
      .set_col      (set_col),
      .set_col_val  (set_col_val),
      .set_bank     (set_bank),
      .set_bank_val (set_bank_val),
      .order_q      (order_q),
      .col_lim_q    (col_lim_q),
      .bank_lim_q   (bank_lim_q),
      .col_q        (col_q),
      .bank_q       (bank_q)
   );

   dag_col_map #(
      .COL_W     (COL_W),
      .NUM_COLS  (NUM_COLS),
      .MIRROR_EN (MIRROR_EN)
   ) u_map (
      .col_log  (col_q),
      .mirror   (mirror_q),
      .col_phys (mem_col)
   );

   assign mem_bank = bank_q;
   assign mem_we   = wr_strobe;

endmodule

// File: rtl/disp_ram_addr_gen_chk.sv
module disp_ram_addr_gen_chk #(
   parameter int NUM_COLS  = 102,
   parameter int NUM_BANKS = 9,
   parameter int COL_W     = 7,
   parameter int BANK_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_strobe,
   input logic              set_col,
   input logic [COL_W-1:0]  set_col_val,
   input logic              set_bank,
   input logic              cfg_wr,
   input logic              order_q,
   input logic [COL_W-1:0]  col_q,
   input logic [BANK_W-1:0] bank_q,
   input logic [COL_W-1:0]  col_lim_q,
   input logic [BANK_W-1:0] bank_lim_q,
   input logic [COL_W-1:0]  mem_col,
   input logic [BANK_W-1:0] mem_bank
);

   logic step_ok;
   assign step_ok = wr_strobe && !set_col && !set_bank;

   AST_COL_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mem_col) < NUM_COLS); // R8

   AST_BANK_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mem_bank) < NUM_BANKS); // R9

   AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok && !order_q && (col_q < col_lim_q)
      |=> (int'(col_q) == int'($past(col_q)) + 1) && $stable(bank_q)); // R3

   AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok && !order_q && (col_q >= col_lim_q) && (bank_q < bank_lim_q)
      |=> (col_q == '0) && (int'(bank_q) == int'($past(bank_q)) + 1)); // R4

   AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok && order_q && (bank_q < bank_lim_q)
      |=> (int'(bank_q) == int'($past(bank_q)) + 1) && $stable(col_q)); // R5

   AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok && order_q && (bank_q >= bank_lim_q) && (col_q < col_lim_q)
      |=> (bank_q == '0) && (int'(col_q) == int'($past(col_q)) + 1)); // R6

   AST_BOTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok && (col_q >= col_lim_q) && (bank_q >= bank_lim_q)
      |=> (col_q == '0) && (bank_q == '0)); // R7

   AST_SET_COL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      set_col |=> col_q == (($past(set_col_val) > $past(col_lim_q)) ?
                            $past(col_lim_q) : $past(set_col_val))); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe && !set_col && !set_bank && !cfg_wr
      |=> $stable(mem_col) && $stable(mem_bank)); // R11

endmodule

bind disp_ram_addr_gen disp_ram_addr_gen_chk #(
   .NUM_COLS  (NUM_COLS),
   .NUM_BANKS (NUM_BANKS),
   .COL_W     (COL_W),
   .BANK_W    (BANK_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_strobe   (wr_strobe),
   .set_col     (set_col),
   .set_col_val (set_col_val),
   .set_bank    (set_bank),
   .cfg_wr      (cfg_wr),
   .order_q     (order_q),
   .col_q       (col_q),
   .bank_q      (bank_q),
   .col_lim_q   (col_lim_q),
   .bank_lim_q  (bank_lim_q),
   .mem_col     (mem_col),
   .mem_bank    (mem_bank)
);

// File: tb/disp_ram_addr_gen_tb.sv
`timescale 1ns/1ps
module disp_ram_addr_gen_tb;

   localparam int NC = 102;
   localparam int NB = 9;
   localparam int CW = $clog2(NC);
   localparam int BW = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_strobe = 1'b0;
   logic          set_col = 1'b0;
   logic [CW-1:0] set_col_val = '0;
   logic          set_bank = 1'b0;
   logic [BW-1:0] set_bank_val = '0;
   logic          cfg_wr = 1'b0;
   logic          cfg_vert = 1'b0;
   logic          cfg_mirror = 1'b0;
   logic [CW-1:0] cfg_col_lim = '0;
   logic [BW-1:0] cfg_bank_lim = '0;
   logic [BW-1:0] mem_bank;
   logic [CW-1:0] mem_col;
   logic          mem_we;

   always #5 clk = ~clk;

   disp_ram_addr_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_strobe    (wr_strobe),
      .set_col      (set_col),
      .set_col_val  (set_col_val),
      .set_bank     (set_bank),
      .set_bank_val (set_bank_val),
      .cfg_wr       (cfg_wr),
      .cfg_vert     (cfg_vert),
      .cfg_mirror   (cfg_mirror),
      .cfg_col_lim  (cfg_col_lim),
      .cfg_bank_lim (cfg_bank_lim),
      .mem_bank     (mem_bank),
      .mem_col      (mem_col),
      .mem_we       (mem_we)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   // reference state
   int m_col = 0, m_bank = 0, m_v = 0, m_mx = 0, m_xl = NC - 1, m_yl = NB - 1;

   function automatic int clampi(input int v, input int lim);
      return (v > lim) ? lim : v;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit s, input bit sc, input int scv, input bit sb, input int sbv,
                      input bit cw, input bit cv, input bit cm, input int cxl, input int cyl);
      int exp_col;
      @(negedge clk);
      wr_strobe    = s;
      set_col      = sc;
      set_col_val  = CW'(scv);
      set_bank     = sb;
      set_bank_val = BW'(sbv);
      cfg_wr       = cw;
      cfg_vert     = cv;
      cfg_mirror   = cm;
      cfg_col_lim  = CW'(cxl);
      cfg_bank_lim = BW'(cyl);
      #1;
      exp_col = (m_mx != 0) ? (NC - 1 - m_col) : m_col;
      check((m_mx != 0) ? "R8" : tag, "mem_col", int'(mem_col), exp_col);
      check(tag, "mem_bank", int'(mem_bank), m_bank);
      check("R2", "mem_we", int'(mem_we), int'(s));
      // reference update for the coming edge
      if (sc || sb) begin
         if (sc) m_col = clampi(scv, m_xl);
         if (sb) m_bank = clampi(sbv, m_yl);
      end else if (s) begin
         if (m_v == 0) begin
            if (m_col >= m_xl) begin
               m_col = 0;
               m_bank = (m_bank >= m_yl) ? 0 : m_bank + 1;
            end else m_col++;
         end else begin
            if (m_bank >= m_yl) begin
               m_bank = 0;
               m_col = (m_col >= m_xl) ? 0 : m_col + 1;
            end else m_bank++;
         end
      end
      if (cw) begin
         m_v  = int'(cv);
         m_mx = int'(cm);
         m_xl = clampi(cxl, NC - 1);
         m_yl = clampi(cyl, NB - 1);
      end
   endtask

   task automatic wr(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic cfg(input bit v, input bit mx, input int xl, input int yl);
      cyc(0, 0, 0, 0, 0, 1, v, mx, xl, yl);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      check("R1", "reset mem_col", int'(mem_col), 0);
      check("R1", "reset mem_bank", int'(mem_bank), 0);
      check("R1", "reset mem_we", int'(mem_we), 0);

      // R1/R3/R4: default limits, horizontal sweep across column 101 wrap
      tag = "R3";
      wr(100);
      tag = "R4";
      wr(12);
      tag = "R11";
      idle(4);

      // R10: small limits, counters untouched by the config write
      tag = "R10";
      cfg(0, 0, 5, 2);
      idle(1);
      cyc(0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
      tag = "R4";
      wr(8);
      tag = "R7";
      wr(14);

      // R5/R6/R7: vertical order
      tag = "R5";
      cfg(1, 0, 5, 2);
      wr(2);
      tag = "R6";
      wr(10);
      tag = "R7";
      wr(10);

      // R8: mirroring, vertical then horizontal
      cfg(1, 1, 5, 2);
      wr(20);
      cfg(0, 1, 101, 8);
      wr(30);
      idle(2);

      // R9: loads, clamping and priority over the strobe
      tag = "R9";
      cfg(0, 0, 5, 2);
      cyc(0, 1, 50, 1, 7, 0, 0, 0, 0, 0);
      cyc(1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      wr(3);

      // R10: oversize limits clamp to the array, then R7 double wrap
      tag = "R10";
      cfg(0, 0, 127, 15);
      cyc(1, 0, 0, 0, 0, 1, 1, 0, 4, 1); // strobe and config write together
      cfg(0, 0, 127, 15);
      cyc(0, 1, 127, 1, 15, 0, 0, 0, 0, 0);
      tag = "R7";
      wr(2);

      // R2: mixed traffic
      tag = "R2";
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 4)
            cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 127), $urandom_range(0, 15));
         else if (r < 8)
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 127),
                1'($urandom_range(0, 1)), $urandom_range(0, 15), 0, 0, 0, 0, 0);
         else if (r < 80)
            wr(1);
         else
            idle(1);
      end
      idle(2);
      finish_run();
   end

endmodule